// File: doc/BRIEF.md
# Write-Unlock Command Sequencer

This block sits behind a multiplexed-bus memory interface and guards a non-volatile array against stray writes. It watches every write strobe (address and data, already demultiplexed) and keeps the array locked until three command writes arrive in a fixed order: data 0xAA to address 0x5555, then 0x55 to 0x2AAA, then 0xA0 to 0x5555. Each of these writes must come within a byte-load window of the previous one. The window is measured in ticks of a free-running microsecond strobe and defaults to 100 ticks.

Once the third command write lands, the block raises a grant level that opens a page-load session. Later writes pass through as data bytes as long as each one arrives inside the window of the one before it. When the window runs out with no write, the session closes, the grant drops, and the next programming operation needs a fresh unlock. A command sequence that breaks part-way, either by a wrong write or by a window timeout, gives a one-cycle abort pulse and grants nothing. Writes presented while the block is locked are simply ignored.

The state machine has four states. `ST_IDLE` is locked. `ST_STEP2` means step one was seen and step two is awaited. `ST_STEP3` means steps one and two were seen. `ST_SESSION` means the grant is open.

The transitions are:
- *arm*: `ST_IDLE` to `ST_STEP2` on the first command write.
- *advance*: `ST_STEP2` to `ST_STEP3` on the second command write.
- *open*: `ST_STEP3` to `ST_SESSION` on the third command write.
- *restart*: `ST_STEP2` or `ST_STEP3` to `ST_STEP2` on a stray write that is itself the first command.
- *break*: `ST_STEP2` or `ST_STEP3` to `ST_IDLE` on any other write.
- *lapse*: `ST_STEP2` or `ST_STEP3` to `ST_IDLE` on window expiry.
- *load*: `ST_SESSION` stays in `ST_SESSION` on a data write, which restarts the window.
- *close*: `ST_SESSION` to `ST_IDLE` on window expiry.

Restart, break and lapse raise the abort pulse.

Top module: `unlock_seq`

## Requirements
- R1: After reset, `wr_grant` is 0 and `seq_abort` is 0.
- R2: While locked, a write that is not the first command (data 0xAA at address 0x5555) leaves `wr_grant` at 0 and `seq_abort` at 0. This includes the second or third command presented out of order.
- R3: The writes 0xAA@0x5555, 0x55@0x2AAA and 0xA0@0x5555, each inside the window of the previous, make `wr_grant` go to 1 in the cycle after the third write's strobe cycle.
- R4: In the second or third step, a write whose address or data differs from the awaited command returns the block to locked. `seq_abort` is 1 for exactly the following cycle, and `wr_grant` stays 0.
- R5: In the second or third step, a stray write equal to the first command pulses `seq_abort` and counts as a new first step. The second and third commands that follow it then open the grant.
- R6: If WINDOW_US ticks of `us_tick` pass after a command write with no further write, the block returns to locked and pulses `seq_abort` in the cycle after the WINDOW_US-th tick.
- R7: A write presented after WINDOW_US-1 ticks is in time. A write presented in the same cycle as the WINDOW_US-th tick is also in time, because the write wins over expiry.
- R8: During a session, every write keeps `wr_grant` at 1 and restarts the window.
- R9: A session closes with no abort when WINDOW_US ticks pass after its last write. `wr_grant` drops to 0 in the cycle after the WINDOW_US-th tick, and a data write after that does not reopen it.
- R10: While locked, `us_tick` has no effect on either output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_pulse | input | 1 | One-cycle strobe: a bus write occurred |
| wr_addr | input | ADDR_W (15) | Latched write address |
| wr_data | input | DATA_W (8) | Write data |
| us_tick | input | 1 | One-cycle strobe each microsecond |
| wr_grant | output | 1 | High while a page-load session is open |
| seq_abort | output | 1 | One-cycle pulse when an in-progress command sequence is abandoned |

## Verification
The scoreboard drives clean unlock sequences, and sequences corrupted at each step by a wrong address, a wrong data value, or a repeated first command. This separates plain break handling from the restart path. Tick streams are placed exactly one tick short of expiry, exactly at expiry, and at expiry together with a write. This pins down the off-by-one edge of the window and the priority of a write over a timeout. Lock-time traffic (out-of-order commands, idle ticks, and data writes after a session has closed) shows that nothing but the full sequence opens the grant.

// File: rtl/unlock_pkg.sv
`timescale 1ns/1ps
package unlock_pkg;
    localparam int UNLK_NSTEPS = 3;

    // Command table, element 0 is the first step.
    localparam logic [UNLK_NSTEPS-1:0][14:0] UNLK_ADDR_DFLT = {15'h5555, 15'h2AAA, 15'h5555};
    localparam logic [UNLK_NSTEPS-1:0][7:0]  UNLK_DATA_DFLT = {8'hA0, 8'h55, 8'hAA};

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_STEP2   = 2'd1,
        ST_STEP3   = 2'd2,
        ST_SESSION = 2'd3
    } unlk_state_e;
endpackage

// File: rtl/unlock_step_match.sv
`timescale 1ns/1ps
module unlock_step_match #(
    parameter int NSTEPS = 3,
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8,
    parameter logic [NSTEPS-1:0][ADDR_W-1:0] STEP_ADDR = '0,
    parameter logic [NSTEPS-1:0][DATA_W-1:0] STEP_DATA = '0
) (
    input  logic              wr_pulse,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [NSTEPS-1:0] hit
);
    // One comparator per command step; a hit needs a live strobe.
    for (genvar s = 0; s < NSTEPS; s++) begin : g_step
        assign hit[s] = wr_pulse
                     && (wr_addr == STEP_ADDR[s])
                     && (wr_data == STEP_DATA[s]);
    end
endmodule

// File: rtl/unlock_window_timer.sv
`timescale 1ns/1ps
module unlock_window_timer #(
    parameter int WINDOW_US = 100,
    localparam int CNT_W    = $clog2(WINDOW_US + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic restart,
    input  logic tick,
    output logic expire
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW_US - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !armed || restart) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // A write in the same cycle wins over expiry.
    assign expire = armed && tick && !restart && (cnt_q == LAST);
endmodule

// File: rtl/unlock_seq_fsm.sv
`timescale 1ns/1ps
module unlock_seq_fsm
    import unlock_pkg::*;
#(
    parameter int NSTEPS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_pulse,
    input  logic [NSTEPS-1:0] hit,
    input  logic              expire,
    output logic              armed,
    output logic              grant,
    output logic              abort
);
    unlk_state_e state_q, state_d;
    logic        abort_d;

    always_comb begin
        state_d = state_q;
        abort_d = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (hit[0]) state_d = ST_STEP2;                  // arm
            end
            ST_STEP2: begin
                if (wr_pulse) begin
                    if (hit[1]) begin
                        state_d = ST_STEP3;                      // advance
                    end else begin
                        abort_d = 1'b1;
                        state_d = hit[0] ? ST_STEP2 : ST_IDLE;   // restart / break
                    end
                end else if (expire) begin
                    abort_d = 1'b1;
                    state_d = ST_IDLE;                           // lapse
                end
            end
            ST_STEP3: begin
                if (wr_pulse) begin
                    if (hit[NSTEPS-1]) begin
                        state_d = ST_SESSION;                    // open
                    end else begin
                        abort_d = 1'b1;
                        state_d = hit[0] ? ST_STEP2 : ST_IDLE;   // restart / break
                    end
                end else if (expire) begin
                    abort_d = 1'b1;
                    state_d = ST_IDLE;                           // lapse
                end
            end
            ST_SESSION: begin
                if (!wr_pulse && expire) state_d = ST_IDLE;      // close; write = load
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant <= 1'b0;
            abort <= 1'b0;
        end else begin
            grant <= (state_d == ST_SESSION);
            abort <= abort_d;
        end
    end

    assign armed = (state_q != ST_IDLE);
endmodule

// File: rtl/unlock_seq.sv
`timescale 1ns/1ps
module unlock_seq
    import unlock_pkg::*;
#(
    parameter int ADDR_W    = 15,
    parameter int DATA_W    = 8,
    parameter int WINDOW_US = 100,
    parameter logic [UNLK_NSTEPS-1:0][ADDR_W-1:0] STEP_ADDR = UNLK_ADDR_DFLT,
    parameter logic [UNLK_NSTEPS-1:0][DATA_W-1:0] STEP_DATA = UNLK_DATA_DFLT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_pulse,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              us_tick,
    output logic              wr_grant,
    output logic              seq_abort
);
    localparam int NSTEPS = UNLK_NSTEPS;

    logic [NSTEPS-1:0] hit;
    logic              armed;
    logic              expire;

    unlock_step_match #(
        .NSTEPS(NSTEPS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .STEP_ADDR(STEP_ADDR), .STEP_DATA(STEP_DATA)
    ) u_match (
        .wr_pulse(wr_pulse), .wr_addr(wr_addr), .wr_data(wr_data), .hit(hit)
    );

    unlock_window_timer #(.WINDOW_US(WINDOW_US)) u_timer (
        .clk(clk), .rst_n(rst_n), .armed(armed),
        .restart(wr_pulse), .tick(us_tick), .expire(expire)
    );

    unlock_seq_fsm #(.NSTEPS(NSTEPS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_pulse(wr_pulse), .hit(hit),
        .expire(expire), .armed(armed), .grant(wr_grant), .abort(seq_abort)
    );
endmodule

// File: rtl/unlock_seq_chk.sv
`timescale 1ns/1ps
module unlock_seq_chk #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] LAST_ADDR = '0,
    parameter logic [DATA_W-1:0] LAST_DATA = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_pulse,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              us_tick,
    input logic              wr_grant,
    input logic              seq_abort
);
    AST_GRANT_OPENS_ON_LAST_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_grant) |-> ($past(wr_pulse) && $past(wr_addr) == LAST_ADDR
                             && $past(wr_data) == LAST_DATA)); // R3

    AST_LOCKED_WRITE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_grant && wr_pulse && !(wr_addr == LAST_ADDR && wr_data == LAST_DATA))
        |=> !wr_grant); // R2

    AST_ABORT_OUTSIDE_SESSION: assert property (@(posedge clk) disable iff (!rst_n)
        seq_abort |-> (!wr_grant && !$past(wr_grant))); // R4

    AST_ABORT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_abort |-> ($past(wr_pulse) || $past(us_tick))); // R6

    AST_CLOSE_ON_QUIET_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_grant) |-> (!$past(wr_pulse) && $past(us_tick) && !seq_abort)); // R9
endmodule

bind unlock_seq unlock_seq_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .LAST_ADDR(STEP_ADDR[UNLK_NSTEPS-1]), .LAST_DATA(STEP_DATA[UNLK_NSTEPS-1])
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_pulse(wr_pulse), .wr_addr(wr_addr),
    .wr_data(wr_data), .us_tick(us_tick), .wr_grant(wr_grant), .seq_abort(seq_abort)
);

// File: tb/test_unlock_seq.sv
`timescale 1ns/1ps
module test_unlock_seq;
    localparam int W = 100;
    localparam logic [14:0] CA = 15'h5555;
    localparam logic [14:0] CB = 15'h2AAA;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_pulse = 1'b0;
    logic [14:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        us_tick = 1'b0;
    logic        wr_grant, seq_abort;

    int tests = 0;
    int fails = 0;

    typedef struct {
        logic  g;
        logic  a;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    unlock_seq #(.WINDOW_US(W)) i_unlock_seq (
        .clk(clk), .rst_n(rst_n), .wr_pulse(wr_pulse), .wr_addr(wr_addr),
        .wr_data(wr_data), .us_tick(us_tick), .wr_grant(wr_grant), .seq_abort(seq_abort)
    );

    // Driver: one cycle of stimulus plus the outputs expected after its edge.
    task automatic cyc(input logic w, input logic [14:0] a, input logic [7:0] d,
                       input logic tk, input logic eg, input logic ea, input string tag);
        @(negedge clk);
        wr_pulse = w; wr_addr = a; wr_data = d; us_tick = tk;
        sb.push_back('{eg, ea, tag});
    endtask

    task automatic wr(input logic [14:0] a, input logic [7:0] d,
                      input logic eg, input logic ea, input string tag);
        cyc(1'b1, a, d, 1'b0, eg, ea, tag);
    endtask

    task automatic ticks(input int n, input logic eg, input string tag);
        for (int i = 0; i < n; i++) cyc(1'b0, '0, '0, 1'b1, eg, 1'b0, tag);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // Monitor: pops one expectation per edge, just after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                tests++;
                if (wr_grant !== e.g || seq_abort !== e.a) begin
                    fails++;
                    $display("FAIL %s: grant/abort actual %b/%b expected %b/%b",
                             e.tag, wr_grant, seq_abort, e.g, e.a);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        tests++;
        if (wr_grant !== 1'b0 || seq_abort !== 1'b0) begin
            fails++;
            $display("FAIL R1: grant/abort actual %b/%b expected 0/0", wr_grant, seq_abort);
        end

        // R2: locked, stray and out-of-order commands are ignored
        wr(15'h1234, 8'h12, 0, 0, "R2 stray");
        wr(CA, 8'hA0, 0, 0, "R2 third first");
        wr(CB, 8'h55, 0, 0, "R2 second first");
        // R10: ticks while locked
        ticks(150, 0, "R10 idle ticks");

        // R3: clean unlock
        wr(CA, 8'hAA, 0, 0, "R3 step1");
        wr(CB, 8'h55, 0, 0, "R3 step2");
        wr(CA, 8'hA0, 1, 0, "R3 grant");
        // R8: session writes keep grant and restart window
        wr(15'h0100, 8'h11, 1, 0, "R8 data");
        wr(15'h0101, 8'h22, 1, 0, "R8 data");
        wr(15'h0102, 8'hAA, 1, 0, "R8 data");
        ticks(W - 1, 1, "R8 window");
        wr(15'h0103, 8'h44, 1, 0, "R8 restart");
        ticks(W - 1, 1, "R8 window2");
        cyc(0, '0, '0, 1, 0, 0, "R9 close");
        // R9: no reopen without unlock
        wr(15'h0100, 8'h33, 0, 0, "R9 relock");
        ticks(3, 0, "R9 idle");

        // R4: wrong address at step 2
        wr(CA, 8'hAA, 0, 0, "R4 s1");
        wr(15'h2AAB, 8'h55, 0, 1, "R4 bad addr");
        cyc(0, '0, '0, 0, 0, 0, "R4 one cycle");
        // R4: wrong data at step 3
        wr(CA, 8'hAA, 0, 0, "R4 s1");
        wr(CB, 8'h55, 0, 0, "R4 s2");
        wr(CA, 8'hA1, 0, 1, "R4 bad data3");
        wr(CA, 8'hA0, 0, 0, "R4 locked after");
        // R4: wrong data at step 2
        wr(CA, 8'hAA, 0, 0, "R4 s1");
        wr(CB, 8'h56, 0, 1, "R4 bad data2");

        // R5: restart from step-2 wait
        wr(CA, 8'hAA, 0, 0, "R5 s1");
        wr(CA, 8'hAA, 0, 1, "R5 restart");
        wr(CB, 8'h55, 0, 0, "R5 s2");
        wr(CA, 8'hA0, 1, 0, "R5 grant");
        ticks(W - 1, 1, "R5 hold");
        cyc(0, '0, '0, 1, 0, 0, "R5 close");
        // R5: restart from step-3 wait
        wr(CA, 8'hAA, 0, 0, "R5 s1b");
        wr(CB, 8'h55, 0, 0, "R5 s2b");
        wr(CA, 8'hAA, 0, 1, "R5 restart3");
        wr(CB, 8'h55, 0, 0, "R5 s2c");
        wr(CA, 8'hA0, 1, 0, "R5 grant2");
        ticks(W - 1, 1, "R5 hold2");
        cyc(0, '0, '0, 1, 0, 0, "R5 close2");

        // R6: timeout at step 2 and step 3
        wr(CA, 8'hAA, 0, 0, "R6 s1");
        ticks(W - 1, 0, "R6 wait");
        cyc(0, '0, '0, 1, 0, 1, "R6 lapse");
        wr(CB, 8'h55, 0, 0, "R6 late s2");
        wr(CA, 8'hAA, 0, 0, "R6 s1b");
        wr(CB, 8'h55, 0, 0, "R6 s2b");
        ticks(W - 1, 0, "R6 wait3");
        cyc(0, '0, '0, 1, 0, 1, "R6 lapse3");
        wr(CA, 8'hA0, 0, 0, "R6 late s3");

        // R7: writes at the edge of the window
        wr(CA, 8'hAA, 0, 0, "R7 s1");
        ticks(W - 1, 0, "R7 wait");
        wr(CB, 8'h55, 0, 0, "R7 s2 in time");
        ticks(W - 1, 0, "R7 wait2");
        cyc(1, CA, 8'hA0, 1, 1, 0, "R7 write beats expiry");
        ticks(W - 1, 1, "R7 hold");
        cyc(0, '0, '0, 1, 0, 0, "R7 close");

        cyc(0, '0, '0, 0, 0, 0, "R1 quiet");
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule